// File: doc/BRIEF.md
# Flag-Based Compare ALU

A purely combinational 16-bit arithmetic unit for a small pipelined register machine. It takes an 8-bit opcode and two operands and returns one result word. Addition, subtraction and multiplication give their arithmetic result, truncated to the operand width. The five ordering and equality tests share one subtractor. Each test reads only the negative and zero flags of the difference `a - b` and combines them in a fixed Boolean way. The test gives 1 when it is true and 0 when it is false.

The flags come straight from the 16-bit difference. No overflow correction is made, so an ordering test whose difference wraps follows the sign bit and not the true signed order. Opcodes that the unit does not compute pass operand `a` through unchanged, so an upstream copy can use the same path. A separate output tells the pipeline whether the opcode writes a destination register. Division is not computed.

Top module: `aluFlagCmp`

## Requirements
- R1: Opcode 0x01 gives `result = (a + b)` modulo 2^16.
- R2: Opcode 0x03 gives `result = (a - b)` modulo 2^16.
- R3: Opcode 0x02 gives the low 16 bits of the product `a * b`.
- R4: For every opcode, `zero` is 1 exactly when the 16-bit difference `a - b` is all zeros, and `negative` equals bit 15 of that difference.
- R5: Opcode 0x09 (equal) gives Z.
- R6: Opcode 0x0A (less) gives N.
- R7: Opcode 0x0B (less or equal) gives N or Z.
- R8: Opcode 0x0C (greater) gives not (N or Z).
- R9: Opcode 0x0D (greater or equal) gives not N.
- R10: For opcodes 0x09 to 0x0D the test outcome is in result bit 0 and result bits 15:1 are zero.
- R11: Every other opcode gives `result = a`. This includes division, 0x04.
- R12: `writesReg` is 1 for opcodes 0x01, 0x02, 0x03, 0x05, 0x06, 0x07 and 0x09 to 0x0D, and 0 for every other opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | Operation code |
| a | input | 16 | First operand, the minuend |
| b | input | 16 | Second operand, the subtrahend |
| result | output | 16 | Arithmetic result, 0/1 test outcome, or `a` passed through |
| zero | output | 1 | Set when `a - b` is zero |
| negative | output | 1 | Bit 15 of `a - b` |
| writesReg | output | 1 | The opcode writes a destination register |

## Verification
The block holds no state, so a fault in its decode or flag logic shows at the ports in the same cycle as the stimulus. A wrong flag polarity or a swapped combination shows only for operand pairs on one side of a boundary. The directed cases therefore use equal operands, pairs that differ by one, and pairs whose difference wraps past the sign bit. A decode fault shows as a test outcome with upper bits set, as an operand leaking through, or as a wrong `writesReg` on an unlisted opcode.

// File: rtl/aluFlagCmp_pkg.sv
package aluFlagCmp_pkg;

  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OP_ADD  = 8'h01;
  localparam logic [OP_W-1:0] OP_MUL  = 8'h02;
  localparam logic [OP_W-1:0] OP_SUB  = 8'h03;
  localparam logic [OP_W-1:0] OP_DIV  = 8'h04;
  localparam logic [OP_W-1:0] OP_COPY = 8'h05;
  localparam logic [OP_W-1:0] OP_IMM  = 8'h06;
  localparam logic [OP_W-1:0] OP_LOAD = 8'h07;
  localparam logic [OP_W-1:0] OP_EQ   = 8'h09;
  localparam logic [OP_W-1:0] OP_LT   = 8'h0A;
  localparam logic [OP_W-1:0] OP_LE   = 8'h0B;
  localparam logic [OP_W-1:0] OP_GT   = 8'h0C;
  localparam logic [OP_W-1:0] OP_GE   = 8'h0D;

  typedef enum logic [2:0] {
    CMP_NONE = 3'd0,
    CMP_EQ   = 3'd1,
    CMP_LT   = 3'd2,
    CMP_LE   = 3'd3,
    CMP_GT   = 3'd4,
    CMP_GE   = 3'd5
  } cmpKind_e;

  typedef struct packed {
    logic     selAdd;
    logic     selMul;
    logic     selSub;
    cmpKind_e cmpKind;
    logic     wrReg;
  } aluStrobe_t;

endpackage

// File: rtl/aluFlagCmp_ctrl.sv
module aluFlagCmp_ctrl
  import aluFlagCmp_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output aluStrobe_t      strb
);

  always_comb begin
    strb = '0;
    strb.cmpKind = CMP_NONE;
    case (opcode)
      OP_ADD:  begin strb.selAdd = 1'b1; strb.wrReg = 1'b1; end
      OP_MUL:  begin strb.selMul = 1'b1; strb.wrReg = 1'b1; end
      OP_SUB:  begin strb.selSub = 1'b1; strb.wrReg = 1'b1; end
      OP_COPY: strb.wrReg = 1'b1;
      OP_IMM:  strb.wrReg = 1'b1;
      OP_LOAD: strb.wrReg = 1'b1;
      OP_EQ:   begin strb.cmpKind = CMP_EQ; strb.wrReg = 1'b1; end
      OP_LT:   begin strb.cmpKind = CMP_LT; strb.wrReg = 1'b1; end
      OP_LE:   begin strb.cmpKind = CMP_LE; strb.wrReg = 1'b1; end
      OP_GT:   begin strb.cmpKind = CMP_GT; strb.wrReg = 1'b1; end
      OP_GE:   begin strb.cmpKind = CMP_GE; strb.wrReg = 1'b1; end
      default: strb.wrReg = 1'b0; // division and all others: no write
    endcase
  end

endmodule

// File: rtl/aluFlagCmp_path.sv
module aluFlagCmp_path
  import aluFlagCmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  aluStrobe_t       strb,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             negative
);

  localparam int PAD_W = WIDTH - 1;

  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] prod;
  logic             cmpBit;

  // one shared subtractor feeds SUB, both flags and all tests
  assign diff     = a - b;
  assign sum      = a + b;
  assign prod     = a * b;
  assign negative = diff[WIDTH-1];
  assign zero     = (diff == '0);

  always_comb begin
    case (strb.cmpKind)
      CMP_EQ:  cmpBit = zero;
      CMP_LT:  cmpBit = negative;
      CMP_LE:  cmpBit = negative | zero;
      CMP_GT:  cmpBit = ~(negative | zero);
      CMP_GE:  cmpBit = ~negative;
      default: cmpBit = 1'b0;
    endcase
  end

  always_comb begin
    if (strb.cmpKind != CMP_NONE) result = {{PAD_W{1'b0}}, cmpBit};
    else if (strb.selAdd)         result = sum;
    else if (strb.selMul)         result = prod;
    else if (strb.selSub)         result = diff;
    else                          result = a;
  end

endmodule

// File: rtl/aluFlagCmp.sv
module aluFlagCmp
  import aluFlagCmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [OP_W-1:0]  opcode,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             negative,
  output logic             writesReg
);

  aluStrobe_t strb;

  aluFlagCmp_ctrl u_ctrl (
    .opcode (opcode),
    .strb   (strb)
  );

  aluFlagCmp_path #(.WIDTH(WIDTH)) u_path (
    .a        (a),
    .b        (b),
    .strb     (strb),
    .result   (result),
    .zero     (zero),
    .negative (negative)
  );

  assign writesReg = strb.wrReg;

endmodule

// File: rtl/aluFlagCmp_chk.sv
module aluFlagCmp_chk
  import aluFlagCmp_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input logic [OP_W-1:0]  opcode,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] result,
  input logic             zero,
  input logic             negative,
  input logic             writesReg
);

  logic isCmp;
  assign isCmp = (opcode >= OP_EQ) && (opcode <= OP_GE);

  always_comb begin
    // R4
    zero_flag_chk: assert (zero == (a == b))
      else $error("zero flag disagrees with operand equality");
    // R5
    eq_flag_chk: assert (!(opcode == OP_EQ) || (result[0] == zero))
      else $error("equal test not driven by Z");
    // R6
    lt_flag_chk: assert (!(opcode == OP_LT) || (result[0] == negative))
      else $error("less test not driven by N");
    // R9
    ge_flag_chk: assert (!(opcode == OP_GE) || (result[0] == !negative))
      else $error("greater-or-equal test not the inverse of N");
    // R8
    gt_excl_chk: assert (!(opcode == OP_GT) || !(result[0] && (zero || negative)))
      else $error("greater test true with N or Z set");
    // R10
    cmp_upper_chk: assert (!isCmp || (result[WIDTH-1:1] == '0))
      else $error("test outcome has upper bits set");
    // R11
    div_pass_chk: assert (!(opcode == OP_DIV) || (result == a))
      else $error("division opcode did not pass a");
    // R12
    div_nowr_chk: assert (!(opcode == OP_DIV) || !writesReg)
      else $error("division opcode flagged as register write");
  end

endmodule

bind aluFlagCmp aluFlagCmp_chk #(.WIDTH(WIDTH)) u_chk (
  .opcode    (opcode),
  .a         (a),
  .b         (b),
  .result    (result),
  .zero      (zero),
  .negative  (negative),
  .writesReg (writesReg)
);

// File: tb/aluFlagCmp_tb.sv
module aluFlagCmp_tb;

  logic        clk = 1'b0;
  logic [7:0]  opcode;
  logic [15:0] a, b;
  logic [15:0] result;
  logic        zero, negative, writesReg;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  aluFlagCmp u_dut (
    .opcode    (opcode),
    .a         (a),
    .b         (b),
    .result    (result),
    .zero      (zero),
    .negative  (negative),
    .writesReg (writesReg)
  );

  function automatic logic [15:0] expResult(input logic [7:0] op, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] d;
    logic n, z;
    d = x - y;
    n = d[15];
    z = (d == 16'h0);
    case (op)
      8'h01: return x + y;
      8'h02: return 16'(x * y);
      8'h03: return d;
      8'h09: return {15'h0, z};
      8'h0A: return {15'h0, n};
      8'h0B: return {15'h0, n | z};
      8'h0C: return {15'h0, ~(n | z)};
      8'h0D: return {15'h0, ~n};
      default: return x;
    endcase
  endfunction

  function automatic logic expWr(input logic [7:0] op);
    return (op inside {8'h01, 8'h02, 8'h03, 8'h05, 8'h06, 8'h07}) ||
           (op >= 8'h09 && op <= 8'h0D);
  endfunction

  function automatic string reqOf(input logic [7:0] op);
    case (op)
      8'h01: return "R1";
      8'h02: return "R3";
      8'h03: return "R2";
      8'h09: return "R5/R10";
      8'h0A: return "R6/R10";
      8'h0B: return "R7/R10";
      8'h0C: return "R8/R10";
      8'h0D: return "R9/R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: op=%h a=%h b=%h actual=%h expected=%h", req, opcode, a, b, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [15:0] x, input logic [15:0] y);
    logic [15:0] d;
    @(negedge clk);
    opcode = op; a = x; b = y;
    #1;
    d = x - y;
    check(reqOf(op), result, expResult(op, x, y));
    check("R4 zero", {15'h0, zero}, {15'h0, d == 16'h0});
    check("R4 negative", {15'h0, negative}, {15'h0, d[15]});
    check("R12", {15'h0, writesReg}, {15'h0, expWr(op)});
  endtask

  initial begin
    opcode = 8'h00; a = 16'h0; b = 16'h0;
    repeat (2) @(negedge clk);
    // idle inputs: opcode 0 passes a (zero), flags show equality
    check("R11 idle", result, 16'h0000);
    check("R4 idle", {15'h0, zero}, 16'h0001);
    check("R12 idle", {15'h0, writesReg}, 16'h0000);

    // directed corners for every compare: equal, less by one, greater by one, wrap
    for (int op = 8'h09; op <= 8'h0D; op++) begin
      apply(8'(op), 16'h1234, 16'h1234);
      apply(8'(op), 16'h0004, 16'h0005);
      apply(8'(op), 16'h0005, 16'h0004);
      apply(8'(op), 16'h8000, 16'h0001); // wraps: N clear
      apply(8'(op), 16'h7FFF, 16'hFFFF); // wraps: N set
      apply(8'(op), 16'h0000, 16'h0000);
    end
    apply(8'h01, 16'hFFFF, 16'h0001);   // R1 carry out dropped
    apply(8'h03, 16'h0000, 16'h0001);   // R2 borrow wraps
    apply(8'h02, 16'h0100, 16'h0100);   // R3 low half zero
    apply(8'h02, 16'hFFFF, 16'hFFFF);   // R3 low half one
    apply(8'h04, 16'hABCD, 16'h0003);   // R11 division passes a
    apply(8'h05, 16'h5A5A, 16'h1111);   // R11 copy, R12 write
    apply(8'h08, 16'h0F0F, 16'h0F0F);   // R12 store no write
    apply(8'hFF, 16'hC001, 16'h0002);   // R11 unknown opcode

    // constrained random
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] op;
      logic [15:0] x, y;
      op = (($urandom % 4) == 0) ? 8'($urandom) : 8'($urandom % 17);
      x = 16'($urandom);
      y = (($urandom % 8) == 0) ? x + 16'($urandom % 3) - 16'd1 : 16'($urandom);
      apply(op, x, y);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule